// File: doc/BRIEF.md
# 4x4 Inverse Transform Reconstructor

This block rebuilds one 4x4 tile of 8-bit picture samples from its dequantized transform coefficients and the matching prediction tile. A full block goes through a separable fixed-point inverse transform: a one-dimensional butterfly is applied to each row, then the same butterfly is applied to each column of the row results. Each final value is rounded down by a factor of eight and added to the prediction sample. The sum is then clamped to the 8-bit range.

A DC-only mode skips the transform. Only the first coefficient is scaled and added to every prediction sample. Coefficients and prediction arrive on two separate valid/ready ports, and either may arrive first. Pixels leave one per handshake on a third valid/ready port. The block holds one tile at a time.

Top module: `idct4_recon`

## Requirements
- R1: Coefficient k, with k = 4*row + col, sits at `coef_data[16k +: 16]` as a signed value. Prediction sample k sits at `pred_data[8k +: 8]` as an unsigned value. The full transform applies the 1-D pass to every row and then to every column of the row results. Each pass forms even terms e0 = x0 + x2 and e1 = x0 - x2.
- R2: The odd terms of a pass use m(x, K) = (x * K) >>> 16. They are o1 = m(x1, 35468) - (x3 + m(x3, 20091)) and o0 = x1 + m(x1, 20091) + m(x3, 35468). The arithmetic is exact and signed, with no wrap, at any 16-bit input.
- R3: The outputs of a pass, in index order 0..3, are e0 + o0, e1 + o1, e1 - o1 and e0 - o0.
- R4: Each residual is (v + 4) >>> 3, an arithmetic shift. For example, v = -5 gives -1 and v = -4 gives 0.
- R5: Each output pixel is the prediction sample plus the residual, clamped to 0..255.
- R6: When `coef_dc_only` is 1 at coefficient acceptance, every pixel is pred + ((coef0 + 4) >>> 3), clamped. Coefficients 1..15 have no effect.
- R7: The 16 pixels leave in row-major order, index 0 first. `pix_last` is 1 exactly on index 15.
- R8: While `pix_valid` is 1 and `pix_ready` is 0, `pix_valid`, `pix_data` and `pix_last` hold their values into the next cycle.
- R9: `pix_valid` rises only after both a coefficient and a prediction handshake. Each input ready stays 0 from its own handshake until the handoff of pixel 15. Both readies are 1 in the cycle after that handoff.
- R10: During and right after reset, `coef_ready` and `pred_ready` are 1 and `pix_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_valid | input | 1 | Coefficient tile offered |
| coef_ready | output | 1 | Coefficient tile can be taken |
| coef_dc_only | input | 1 | 1 selects the DC-only mode for this tile |
| coef_data | input | 256 | 16 signed 16-bit coefficients |
| pred_valid | input | 1 | Prediction tile offered |
| pred_ready | output | 1 | Prediction tile can be taken |
| pred_data | input | 128 | 16 unsigned 8-bit prediction samples |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Sink takes the pixel |
| pix_data | output | 8 | Reconstructed pixel |
| pix_last | output | 1 | Marks pixel 15 of a tile |

## Verification
The bench targets several corner cases, and each one shows a specific fault:
- **Full-scale coefficients.** A design whose products wrap in 32 bits gives wrong pixels in the column pass.
- **Single-coefficient impulses.** These expose swapped constants and a swapped output order in the butterfly.
- **DC values of -5, -4, 3 and 4.** A logical shift or a missing bias shows up here as an off-by-one.
- **Tiles that push the sum past 255 or below 0.** A design that wraps instead of clamping gives the wrong value.
- **DC tiles with noisy AC coefficients.** These show whether the higher coefficients leak in.
- **A late prediction and random sink stalls.** These catch early output, changing data under backpressure and a misplaced last marker.

// File: rtl/idct4_recon.sv
module idct4_recon #(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             coef_valid,
  output logic             coef_ready,
  input  logic             coef_dc_only,
  input  logic [16*CW-1:0] coef_data,
  input  logic             pred_valid,
  output logic             pred_ready,
  input  logic [16*PW-1:0] pred_data,
  output logic             pix_valid,
  input  logic             pix_ready,
  output logic [PW-1:0]    pix_data,
  output logic             pix_last
);
  localparam int NPIX = 16;
  localparam int IW   = $clog2(NPIX);
  localparam int PMAX = (1 << PW) - 1;

  logic signed [CW-1:0] cq [NPIX];
  logic [PW-1:0]        pq [NPIX];
  logic                 dcm, have_c, have_p;
  logic [IW-1:0]        idx;
  logic signed [31:0]   rowo [NPIX];
  logic signed [31:0]   colo [NPIX];
  logic [PW-1:0]        recon [NPIX];

  function automatic logic signed [31:0] mk(input logic signed [31:0] x, input logic [15:0] k);
    logic signed [47:0] p;
    p = $signed({{16{x[31]}}, x}) * $signed({32'd0, k});
    return p[47:16];
  endfunction

  function automatic void bfly(
    input  logic signed [31:0] x0, x1, x2, x3,
    output logic signed [31:0] y0, y1, y2, y3);
    logic signed [31:0] e0, e1, o0, o1;
    e0 = x0 + x2;
    e1 = x0 - x2;
    o1 = mk(x1, 16'd35468) - (x3 + mk(x3, 16'd20091));
    o0 = x1 + mk(x1, 16'd20091) + mk(x3, 16'd35468);
    y0 = e0 + o0;
    y1 = e1 + o1;
    y2 = e1 - o1;
    y3 = e0 - o0;
  endfunction

  always_comb begin
    for (int r = 0; r < 4; r++)
      bfly(32'(cq[4*r]), 32'(cq[4*r+1]), 32'(cq[4*r+2]), 32'(cq[4*r+3]),
           rowo[4*r], rowo[4*r+1], rowo[4*r+2], rowo[4*r+3]);
    for (int c = 0; c < 4; c++)
      bfly(rowo[c], rowo[4+c], rowo[8+c], rowo[12+c],
           colo[c], colo[4+c], colo[8+c], colo[12+c]);
  end

  always_comb begin
    logic signed [31:0] res, sum;
    for (int k = 0; k < NPIX; k++) begin
      res = dcm ? ((32'(cq[0]) + 32'sd4) >>> 3) : ((colo[k] + 32'sd4) >>> 3);
      sum = res + $signed(32'(pq[k]));
      if (sum < 0)             recon[k] = '0;
      else if (sum > PMAX)     recon[k] = PW'(PMAX);
      else                     recon[k] = sum[PW-1:0];
    end
  end

  assign coef_ready = !have_c;
  assign pred_ready = !have_p;
  assign pix_valid  = have_c & have_p;
  assign pix_data   = recon[idx];
  assign pix_last   = (idx == IW'(NPIX-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_c <= 1'b0;
      have_p <= 1'b0;
      dcm    <= 1'b0;
      idx    <= '0;
      for (int k = 0; k < NPIX; k++) begin
        cq[k] <= '0;
        pq[k] <= '0;
      end
    end else begin
      if (coef_valid && coef_ready) begin
        have_c <= 1'b1;
        dcm    <= coef_dc_only;
        for (int k = 0; k < NPIX; k++) cq[k] <= coef_data[k*CW +: CW];
      end
      if (pred_valid && pred_ready) begin
        have_p <= 1'b1;
        for (int k = 0; k < NPIX; k++) pq[k] <= pred_data[k*PW +: PW];
      end
      if (pix_valid && pix_ready) begin
        idx <= idx + 1'b1;
        if (pix_last) begin
          have_c <= 1'b0;
          have_p <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/idct4_recon_chk.sv
module idct4_recon_chk #(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             coef_valid,
  input logic             coef_ready,
  input logic             coef_dc_only,
  input logic [16*CW-1:0] coef_data,
  input logic             pred_valid,
  input logic             pred_ready,
  input logic [16*PW-1:0] pred_data,
  input logic             pix_valid,
  input logic             pix_ready,
  input logic [PW-1:0]    pix_data,
  input logic             pix_last
);
  logic       got_c, got_p;
  logic [4:0] cnt;
  wire take = pix_valid && pix_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      got_c <= 1'b0;
      got_p <= 1'b0;
      cnt   <= '0;
    end else begin
      if (coef_valid && coef_ready) got_c <= 1'b1;
      if (pred_valid && pred_ready) got_p <= 1'b1;
      if (take) begin
        cnt <= (cnt == 5'd15) ? 5'd0 : cnt + 5'd1;
        if (pix_last) begin
          got_c <= 1'b0;
          got_p <= 1'b0;
        end
      end
    end
  end

  p_order_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (pix_last == (cnt == 5'd15)));
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data) && $stable(pix_last)));
  p_coef_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid && coef_ready) |=> !coef_ready);
  p_pred_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && pred_ready) |=> !pred_ready);
  p_gate_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (got_c && got_p));
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pix_last) |=> (coef_ready && pred_ready && !pix_valid));
  p_reset_idle_r10: assert property (@(posedge clk)
    !rst_n |=> (coef_ready && pred_ready && !pix_valid));
endmodule

bind idct4_recon idct4_recon_chk #(.CW(CW), .PW(PW)) u_chk (.*);

// File: tb/idct4_recon_tb.sv
module idct4_recon_tb;
  typedef int blk_t [16];

  logic         clk = 0;
  logic         rst_n = 0;
  logic         coef_valid = 0, coef_dc_only = 0, pred_valid = 0, pix_ready = 0;
  logic [255:0] coef_data = '0;
  logic [127:0] pred_data = '0;
  logic         coef_ready, pred_ready, pix_valid, pix_last;
  logic [7:0]   pix_data;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  idct4_recon u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint m(longint x, longint k);
    return (x * k) >>> 16;
  endfunction

  function automatic void pass1(input longint x0, x1, x2, x3, output longint y0, y1, y2, y3);
    longint e0, e1, o0, o1;
    e0 = x0 + x2; e1 = x0 - x2;
    o1 = m(x1, 35468) - (x3 + m(x3, 20091));
    o0 = x1 + m(x1, 20091) + m(x3, 35468);
    y0 = e0 + o0; y1 = e1 + o1; y2 = e1 - o1; y3 = e0 - o0;
  endfunction

  function automatic blk_t expect_blk(blk_t cf, blk_t pr, bit dc);
    longint t [16];
    longint v [16];
    longint r, s;
    blk_t e;
    for (int i = 0; i < 4; i++)
      pass1(cf[4*i], cf[4*i+1], cf[4*i+2], cf[4*i+3], t[4*i], t[4*i+1], t[4*i+2], t[4*i+3]);
    for (int j = 0; j < 4; j++)
      pass1(t[j], t[4+j], t[8+j], t[12+j], v[j], v[4+j], v[8+j], v[12+j]);
    for (int k = 0; k < 16; k++) begin
      r = dc ? ((longint'(cf[0]) + 4) >>> 3) : ((v[k] + 4) >>> 3);
      s = r + pr[k];
      e[k] = (s < 0) ? 0 : (s > 255) ? 255 : int'(s);
    end
    return e;
  endfunction

  task automatic run(input blk_t cf, input blk_t pr, input bit dc, input string tag,
                     input bit late, input bit stall);
    blk_t e;
    int k;
    bit stalled;
    logic [7:0] hold;
    e = expect_blk(cf, pr, dc);
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      coef_data[16*i +: 16] = 16'(cf[i]);
      pred_data[8*i +: 8]   = 8'(pr[i]);
    end
    coef_dc_only = dc;
    coef_valid = 1;
    while (!coef_ready) @(negedge clk);
    @(negedge clk);
    coef_valid = 0;
    if (late) begin
      repeat (3) begin
        chk(!pix_valid && !coef_ready && pred_ready, "R9 early-output", int'(pix_valid), 0);
        @(negedge clk);
      end
    end
    pred_valid = 1;
    while (!pred_ready) @(negedge clk);
    @(negedge clk);
    pred_valid = 0;
    k = 0; stalled = 0; hold = '0;
    while (k < 16) begin
      if (stalled) begin
        chk(pix_valid && pix_data == hold, "R8 stall-hold", int'(pix_data), int'(hold));
        stalled = 0;
      end
      pix_ready = stall ? ($urandom % 3 != 0) : 1'b1;
      if (pix_valid && pix_ready) begin
        chk(int'(pix_data) == e[k], tag, int'(pix_data), e[k]);
        chk(pix_last == (k == 15), "R7 last-flag", int'(pix_last), int'(k == 15));
        k++;
      end else if (pix_valid) begin
        stalled = 1;
        hold = pix_data;
      end
      @(negedge clk);
    end
    pix_ready = 0;
    chk(coef_ready && pred_ready && !pix_valid, "R9 release", int'(coef_ready), 1);
  endtask

  function automatic blk_t rnd_pred();
    blk_t p;
    for (int i = 0; i < 16; i++) p[i] = int'($urandom % 256);
    return p;
  endfunction

  function automatic blk_t fill(int val);
    blk_t p;
    for (int i = 0; i < 16; i++) p[i] = val;
    return p;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R7 watchdog: actual hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    blk_t cf, pr;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(coef_ready && pred_ready && !pix_valid, "R10 in-reset", int'(pix_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(coef_ready && pred_ready && !pix_valid, "R10 after-reset", int'(pix_valid), 0);

    cf = fill(0);                  run(cf, rnd_pred(), 0, "R1 zero-coef", 0, 0);
    cf = fill(0); cf[0] = 800;     run(cf, rnd_pred(), 0, "R1 dc-through-transform", 0, 0);
    cf = fill(0); cf[2] = -640;    run(cf, rnd_pred(), 0, "R1 even-term", 0, 1);
    cf = fill(0); cf[1] = 1000;    run(cf, rnd_pred(), 0, "R2 odd-x1", 0, 0);
    cf = fill(0); cf[3] = -1500;   run(cf, rnd_pred(), 0, "R2 odd-x3", 0, 1);
    cf = fill(0); cf[4] = 700; cf[13] = -333; run(cf, rnd_pred(), 0, "R3 column-order", 0, 1);
    cf = fill(32767);              run(cf, fill(255), 0, "R2 full-scale-pos", 0, 0);
    cf = fill(-32768);             run(cf, fill(0), 0, "R2 full-scale-neg", 0, 0);
    cf = fill(0); cf[0] = 32767; cf[5] = 32767; run(cf, fill(250), 0, "R5 clamp-high", 0, 0);
    cf = fill(0); cf[0] = -32768;  run(cf, fill(5), 0, "R5 clamp-low", 0, 0);
    cf = fill(0); cf[0] = -5;      run(cf, fill(100), 1, "R4 dc-minus5", 0, 0);
    cf = fill(0); cf[0] = -4;      run(cf, fill(100), 1, "R4 dc-minus4", 0, 0);
    cf = fill(0); cf[0] = 3;       run(cf, fill(100), 1, "R4 dc-plus3", 0, 0);
    cf = fill(0); cf[0] = 4;       run(cf, fill(100), 1, "R4 dc-plus4", 0, 0);
    cf = fill(9000); cf[0] = 24;   run(cf, rnd_pred(), 1, "R6 dc-ignores-ac", 0, 1);
    cf = fill(0); cf[0] = 2000;    run(cf, fill(200), 1, "R5 dc-clamp", 1, 1);
    cf = fill(0); cf[1] = 50;      run(cf, rnd_pred(), 0, "R3 late-pred", 1, 0);

    for (int n = 0; n < 60; n++) begin
      bit dc;
      dc = ($urandom % 4 == 0);
      for (int i = 0; i < 16; i++)
        cf[i] = (n % 2 == 0) ? (int'($urandom % 601) - 300)
                             : int'($signed(16'($urandom)));
      pr = rnd_pred();
      run(cf, pr, dc, dc ? "R6 random-dc" : "R3 random-full", (n % 7 == 3), 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule